// File: doc/BRIEF.md
# Three-Channel Register-Mapped Watchdog Timer

A watchdog peripheral with several up-counting channels that advance together on a shared reference tick. Each channel compares its running count against a programmable expiry value. Once the count has reached or passed that value, and the channel's reset enable is on, the channel requests a reset. Software keeps a channel from expiring by rewriting its count, usually to zero. The count can be rewritten to any value at any time, and it wraps around rather than stopping at its maximum.

Channel 0 is special in two ways. Its expiry drives a recovery-reset request, while every other channel drives a shared normal-reset request. It also has a second, earlier threshold that sets a sticky interrupt status bit and raises an interrupt line. Software clears that status by writing one to it.

Access is through a plain 32-bit register port with address, write enable, write data and combinational read data. Each channel occupies a 16-byte window, and each register in the window is 4 bytes wide.

Top module: `wdog_multi`

## Requirements
- R1: After reset every count, expiry, threshold and control register reads 0, and `rec_rst_o`, `sys_rst_o` and `irq_o` are low.
- R2: While `tick_i` is high, each channel's count increases by exactly one per clock. While `tick_i` is low, the count holds.
- R3: A register write to a count takes priority over a tick in the same cycle. A count of 0xFFFFFFFF wraps to 0 on the next tick.
- R4: Let N be the clock edge at which a channel's reset enable (control bit 2) is set and its count is greater than or equal to its expiry. The channel's request is high from edge N+1 and stays high for as long as that condition holds. Channel 0 drives `rec_rst_o`. Channels 1 and 2 drive `sys_rst_o`.
- R5: With expiry 0 and count 0, setting reset enable gives a request one clock later, because 0 is greater than or equal to 0.
- R6: Suppose channel 0 has interrupt enable (control bit 0) set and its count is greater than or equal to its threshold. Then, one clock later, status (control bit 1) reads 1 and `irq_o` is high.
- R7: Writing channel 0 control with bit 1 equal to 1 clears the status. Writing it with bit 1 equal to 0 leaves the status unchanged.
- R8: The status stays set after interrupt enable is cleared, but `irq_o` is low whenever interrupt enable is 0.
- R9: Register offsets are as follows. Channel c uses 0x10*c for its count, 0x10*c+4 for its expiry and 0x10*c+0xC for its control. Channel 0 also has its threshold at 0x08. Any other offset, including one that is not a multiple of 4, reads 0 and ignores writes.
- R10: On channels 1 and 2, control bits 0 and 1 always read 0, and those channels never raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick enable; counts advance while high |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| rec_rst_o | output | 1 | Recovery-reset request from channel 0 |
| sys_rst_o | output | 1 | Normal-reset request from channels 1 and above |
| irq_o | output | 1 | Channel 0 threshold interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 6-bit address and three channels. The full 32-bit data width lets a directed write place a count at 0xFFFFFFFF and show the wrap within one tick. The 6-bit address leaves offsets 0x30 to 0x3F, the unused threshold slots of channels 1 and 2, and unaligned addresses open to probing, so the bench can check that these read 0 and ignore writes. With three channels, the bench can show that a channel's request goes to the correct reset output and that channels without an interrupt really lack one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic [1:0] {
      SUB_CNT  = 2'd0,
      SUB_BITE = 2'd1,
      SUB_BARK = 2'd2,
      SUB_CTL  = 2'd3
   } wdog_sub_e;

   localparam int CTL_IRQEN = 0;
   localparam int CTL_STS   = 1;
   localparam int CTL_RSTEN = 2;
   localparam int CTL_W     = 3;
   localparam int WIN_LSB   = 4;
endpackage

// File: rtl/wdog_dec.sv
module wdog_dec
   import wdog_pkg::*;
#(
   parameter int AW  = 6,
   parameter int NCH = 3
) (
   input  logic [AW-1:0]  addr_i,
   output logic [NCH-1:0] sel_o,
   output wdog_sub_e      sub_o
);
   localparam int CW = AW - WIN_LSB;

   logic aligned;
   assign aligned = (addr_i[1:0] == 2'b00);
   assign sub_o   = wdog_sub_e'(addr_i[3:2]);

   for (genvar i = 0; i < NCH; i++) begin : g_sel
      assign sel_o[i] = aligned && (addr_i[AW-1:WIN_LSB] == CW'(i));
   end
endmodule

// File: rtl/wdog_chan.sv
module wdog_chan
   import wdog_pkg::*;
#(
   parameter int DW       = 32,
   parameter bit HAS_BARK = 1'b0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            tick_i,
   input  logic            sel_i,
   input  logic            we_i,
   input  wdog_sub_e       sub_i,
   input  logic [DW-1:0]   wdata_i,
   output logic [DW-1:0]   cnt_o,
   output logic [DW-1:0]   bite_o,
   output logic [DW-1:0]   bark_o,
   output logic [CTL_W-1:0] ctl_o,
   output logic            rq_o
);
   logic          wr_cnt, wr_bite, wr_ctl;
   logic [DW-1:0] cnt_q, bite_q;
   logic          rsten_q, rq_q;

   assign wr_cnt  = we_i && sel_i && (sub_i == SUB_CNT);
   assign wr_bite = we_i && sel_i && (sub_i == SUB_BITE);
   assign wr_ctl  = we_i && sel_i && (sub_i == SUB_CTL);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (wr_cnt) begin
         cnt_q <= wdata_i;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bite_q  <= '0;
         rsten_q <= 1'b0;
         rq_q    <= 1'b0;
      end else begin
         if (wr_bite) bite_q  <= wdata_i;
         if (wr_ctl)  rsten_q <= wdata_i[CTL_RSTEN];
         rq_q <= rsten_q && (cnt_q >= bite_q);
      end
   end

   if (HAS_BARK) begin : g_bark
      logic          wr_bark;
      logic [DW-1:0] bark_q;
      logic          irqen_q, sts_q;
      logic          sts_set, sts_clr;

      assign wr_bark = we_i && sel_i && (sub_i == SUB_BARK);
      assign sts_set = irqen_q && (cnt_q >= bark_q);
      assign sts_clr = wr_ctl && wdata_i[CTL_STS];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            bark_q  <= '0;
            irqen_q <= 1'b0;
            sts_q   <= 1'b0;
         end else begin
            if (wr_bark) bark_q  <= wdata_i;
            if (wr_ctl)  irqen_q <= wdata_i[CTL_IRQEN];
            sts_q <= (sts_q && !sts_clr) || sts_set;
         end
      end

      assign bark_o = bark_q;
      assign ctl_o  = {rsten_q, sts_q, irqen_q};
   end else begin : g_nobark
      assign bark_o = '0;
      assign ctl_o  = {rsten_q, 2'b00};
   end

   assign cnt_o  = cnt_q;
   assign bite_o = bite_q;
   assign rq_o   = rq_q;
endmodule

// File: rtl/wdog_multi.sv
module wdog_multi
   import wdog_pkg::*;
#(
   parameter int DW  = 32,
   parameter int AW  = 6,
   parameter int NCH = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic          rec_rst_o,
   output logic          sys_rst_o,
   output logic          irq_o
);
   if (DW < CTL_W) begin : g_bad_dw
      $error("wdog_multi: DW must hold the control field");
   end
   if (AW < WIN_LSB + 2) begin : g_bad_aw
      $error("wdog_multi: AW too small for the channel windows");
   end
   if (NCH < 2) begin : g_bad_nch_lo
      $error("wdog_multi: NCH must be at least 2");
   end
   if (NCH > (1 << (AW - WIN_LSB))) begin : g_bad_nch_hi
      $error("wdog_multi: NCH does not fit in the address space");
   end

   logic [NCH-1:0]   sel;
   wdog_sub_e        sub;
   logic [DW-1:0]    cnt_a  [NCH];
   logic [DW-1:0]    bite_a [NCH];
   logic [DW-1:0]    bark_a [NCH];
   logic [CTL_W-1:0] ctl_a  [NCH];
   logic [NCH-1:0]   rq;

   wdog_dec #(.AW(AW), .NCH(NCH)) u_dec (
      .addr_i (addr_i),
      .sel_o  (sel),
      .sub_o  (sub)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      wdog_chan #(.DW(DW), .HAS_BARK(i == 0)) u_ch (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .tick_i  (tick_i),
         .sel_i   (sel[i]),
         .we_i    (we_i),
         .sub_i   (sub),
         .wdata_i (wdata_i),
         .cnt_o   (cnt_a[i]),
         .bite_o  (bite_a[i]),
         .bark_o  (bark_a[i]),
         .ctl_o   (ctl_a[i]),
         .rq_o    (rq[i])
      );
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NCH; i++) begin
         if (sel[i]) begin
            unique case (sub)
               SUB_CNT:  rdata_o = cnt_a[i];
               SUB_BITE: rdata_o = bite_a[i];
               SUB_BARK: rdata_o = bark_a[i];
               SUB_CTL:  rdata_o = DW'(ctl_a[i]);
               default:  rdata_o = '0;
            endcase
         end
      end
   end

   logic [DW-1:0]    cnt0_w;
   logic [CTL_W-1:0] ctl0_w;
   assign cnt0_w = cnt_a[0];
   assign ctl0_w = ctl_a[0];

   assign rec_rst_o = rq[0];
   assign sys_rst_o = |rq[NCH-1:1];
   assign irq_o     = ctl0_w[CTL_STS] && ctl0_w[CTL_IRQEN];
endmodule

// File: rtl/wdog_multi_chk.sv
module wdog_multi_chk
   import wdog_pkg::*;
#(
   parameter int DW  = 32,
   parameter int AW  = 6,
   parameter int NCH = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             tick_i,
   input logic             we_i,
   input logic [AW-1:0]    addr_i,
   input logic [DW-1:0]    wdata_i,
   input logic [DW-1:0]    rdata_o,
   input logic             rec_rst_o,
   input logic             irq_o,
   input logic [DW-1:0]    cnt0_i,
   input logic [CTL_W-1:0] ctl0_i
);
   logic wr_cnt0, wr_ctl0, high_win;
   assign wr_cnt0  = we_i && (addr_i == AW'(0));
   assign wr_ctl0  = we_i && (addr_i == AW'(12));
   assign high_win = (int'(addr_i[AW-1:WIN_LSB]) >= NCH);

   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !wr_cnt0) |=> (cnt0_i == $past(cnt0_i) + 1'b1)); // R2
   AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !wr_cnt0) |=> $stable(cnt0_i)); // R2
   AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cnt0 |=> (cnt0_i == $past(wdata_i))); // R3
   AST_REC_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rec_rst_o |-> $past(ctl0_i[CTL_RSTEN])); // R4
   AST_STS_FROM_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctl0_i[CTL_STS]) |-> $past(ctl0_i[CTL_IRQEN])); // R6
   AST_STS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl0_i[CTL_STS] && !(wr_ctl0 && wdata_i[CTL_STS])) |=> ctl0_i[CTL_STS]); // R7
   AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl0_i[CTL_IRQEN] |-> !irq_o); // R8
   AST_UNDEF_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (high_win || (addr_i[1:0] != 2'b00)) |-> (rdata_o == '0)); // R9
endmodule

bind wdog_multi wdog_multi_chk #(.DW(DW), .AW(AW), .NCH(NCH)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .tick_i    (tick_i),
   .we_i      (we_i),
   .addr_i    (addr_i),
   .wdata_i   (wdata_i),
   .rdata_o   (rdata_o),
   .rec_rst_o (rec_rst_o),
   .irq_o     (irq_o),
   .cnt0_i    (cnt0_w),
   .ctl0_i    (ctl0_w)
);

// File: tb/wdog_multi_bench.sv
module wdog_multi_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rec_rst, sys_rst, irq;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_multi u_wdog_multi (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tick_i    (tick),
      .we_i      (we),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .rec_rst_o (rec_rst),
      .sys_rst_o (sys_rst),
      .irq_o     (irq)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      for (int a = 0; a < 64; a += 4) begin
         rd(AW'(a), v);
         chk($sformatf("R1 reg %0h after reset", a), v, '0);
      end
      chk("R1 rec_rst low", DW'(rec_rst), '0);
      chk("R1 sys_rst low", DW'(sys_rst), '0);
      chk("R1 irq low", DW'(irq), '0);
   endtask

   task automatic t_count();
      logic [DW-1:0] v;
      wr(6'h10, 32'd5);
      @(negedge clk); tick = 1'b1;
      repeat (10) @(negedge clk);
      tick = 1'b0;
      rd(6'h10, v);
      chk("R2 ten ticks from 5", v, 32'd15);
      idle(3);
      rd(6'h10, v);
      chk("R2 hold without tick", v, 32'd15);
   endtask

   task automatic t_prio_wrap();
      logic [DW-1:0] v;
      @(negedge clk);
      tick = 1'b1; we = 1'b1; addr = 6'h10; wdata = 32'd100;
      @(negedge clk);
      we = 1'b0; tick = 1'b0;
      rd(6'h10, v);
      chk("R3 write beats tick", v, 32'd100);
      wr(6'h20, 32'hFFFF_FFFF);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      rd(6'h20, v);
      chk("R3 wrap to zero", v, 32'd0);
   endtask

   task automatic t_bite();
      wr(6'h04, 32'd20);
      wr(6'h00, 32'd10);
      wr(6'h0C, 32'd4);
      idle(2);
      chk("R4 below expiry no rec", DW'(rec_rst), '0);
      wr(6'h00, 32'd20);
      idle(1);
      chk("R4 at expiry rec", DW'(rec_rst), 32'd1);
      chk("R4 ch0 not on sys", DW'(sys_rst), '0);
      idle(3);
      chk("R4 rec stays", DW'(rec_rst), 32'd1);
      wr(6'h00, 32'd19);
      idle(1);
      chk("R4 rec drops", DW'(rec_rst), '0);
      wr(6'h0C, 32'd0);
      wr(6'h14, 32'd50);
      wr(6'h10, 32'd60);
      wr(6'h1C, 32'd4);
      idle(1);
      chk("R4 ch1 sys", DW'(sys_rst), 32'd1);
      chk("R4 ch1 not rec", DW'(rec_rst), '0);
      wr(6'h1C, 32'd0);
      idle(1);
      chk("R4 sys drops on disable", DW'(sys_rst), '0);
   endtask

   task automatic t_zero();
      wr(6'h24, 32'd0);
      wr(6'h20, 32'd0);
      wr(6'h2C, 32'd4);
      idle(1);
      chk("R5 zero expiry ch2 sys", DW'(sys_rst), 32'd1);
      wr(6'h2C, 32'd0);
      idle(1);
      chk("R5 ch2 released", DW'(sys_rst), '0);
   endtask

   task automatic t_bark();
      logic [DW-1:0] v;
      wr(6'h08, 32'd30);
      wr(6'h00, 32'd25);
      wr(6'h0C, 32'd1);
      idle(2);
      chk("R6 below threshold no irq", DW'(irq), '0);
      rd(6'h0C, v);
      chk("R6 ctrl en only", v, 32'd1);
      wr(6'h00, 32'd30);
      idle(1);
      chk("R6 irq raised", DW'(irq), 32'd1);
      rd(6'h0C, v);
      chk("R6 status set", v, 32'd3);
      wr(6'h0C, 32'd0);
      idle(1);
      chk("R8 irq gated by enable", DW'(irq), '0);
      rd(6'h0C, v);
      chk("R8 status sticky", v, 32'd2);
      wr(6'h0C, 32'd0);
      rd(6'h0C, v);
      chk("R7 write zero keeps status", v, 32'd2);
      wr(6'h0C, 32'd2);
      rd(6'h0C, v);
      chk("R7 write one clears", v, 32'd0);
      chk("R7 irq low after clear", DW'(irq), '0);
   endtask

   task automatic t_undef();
      logic [DW-1:0] v;
      wr(6'h14, 32'd123);
      wr(6'h18, 32'hFF);
      rd(6'h18, v);
      chk("R9 ch1 threshold slot reads 0", v, '0);
      rd(6'h14, v);
      chk("R9 ch1 expiry untouched", v, 32'd123);
      wr(6'h05, 32'd77);
      rd(6'h04, v);
      chk("R9 unaligned write ignored", v, 32'd20);
      rd(6'h05, v);
      chk("R9 unaligned read 0", v, '0);
      wr(6'h3C, 32'd55);
      rd(6'h3C, v);
      chk("R9 high window reads 0", v, '0);
      rd(6'h30, v);
      chk("R9 offset 30 reads 0", v, '0);
   endtask

   task automatic t_noirq();
      logic [DW-1:0] v;
      wr(6'h10, 32'd0);
      wr(6'h1C, 32'd7);
      rd(6'h1C, v);
      chk("R10 ch1 ctrl low bits zero", v, 32'd4);
      idle(2);
      chk("R10 ch1 no irq", DW'(irq), '0);
      wr(6'h1C, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_prio_wrap();
      t_bite();
      t_zero();
      t_bark();
      t_undef();
      t_noirq();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errs++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule